// File: doc/BRIEF.md
# Timed Stop-Grant Power Controller

This block sequences a processor core into a deep clock-stopped state and back out again. Software starts it by writing a non-zero timeout into a register. The controller then asks the core to flush its pipeline and waits for the bus unit to go idle. In a single apply cycle it may load a new voltage-ID code and a new core-to-bus clock ratio. It then enables clock gating for a fixed time. When the countdown reaches zero, it issues a one-cycle resume strobe together with the instruction-boundary tag that was captured at entry.

While the clocks are gated, the block does three things. It withholds external flush requests from the core. It raises a snoop-blocking indication and flags any snoop request that arrives. It keeps its time-stamp counter and its interrupt-input sampling running. Reset returns it at once to the running state from any point in the sequence.

No data stream passes through the block, so every pin is a plain level or strobe with no valid/ready handshake.

Top module: `stopgrant_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `flush_req`, `clk_gate_en`, `snoop_block`, `snoop_err` and `resume_pulse` are 0, `vid_out` equals RESET_VID (5'h10), `ratio_out` equals RESET_RATIO (3'd2), and `tsc` is 0.
- R2: While idle, a write with `wr_addr`=1 whose low TO_W data bits are non-zero starts a sequence, and `flush_req` is high in the next cycle. Writing zero to that address starts nothing.
- R3: `flush_req` stays high until `pipe_empty` and `bus_idle` are both high in the same cycle. One apply cycle follows, in which neither `flush_req` nor `clk_gate_en` is high, and gating begins in the cycle after that.
- R4: The config register is written with `wr_addr`=0. At entry, `vid_out` takes config bits [4:0] only if config bit 5 is 1. Otherwise it keeps its value.
- R5: At entry, `ratio_out` takes config bits [8:6] only if config bit 10 (the upper bit of the 2-bit ratio control field [10:9]) is 1. Otherwise it keeps its value.
- R6: `clk_gate_en` stays high for exactly T×PRESCALE consecutive cycles, where T is the timeout that was written.
- R7: `resume_pulse` is high for exactly the one cycle after gating ends. In that cycle `resume_tag` equals the `bound_tag` that was sampled in the cycle the drain completed.
- R8: While gating, `vid_out`, `ratio_out` and `flush_req` do not change.
- R9: `flush_fwd` is 0 while gating and follows `ext_flush` at all other times.
- R10: `snoop_block` is high while gating. A `snoop_req` sampled while gating gives `snoop_err`=1 in the next cycle, and `snoop_err` is 0 otherwise.
- R11: `tsc` increases by one every cycle in every state, including gating. `irq_smp` equals `irq_in` delayed by one cycle in every state.
- R12: Driving `rst_n` low forces the idle state immediately from any state and clears the countdown. Gating drops at once, and a later sequence runs for its full length.
- R13: Writes to either register are ignored while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = config, 1 = timeout |
| wr_data | input | DATA_W | Write data |
| pipe_empty | input | 1 | Core pipeline has drained |
| bus_idle | input | 1 | No pending or in-progress bus cycles |
| bound_tag | input | TAG_W | Current instruction-boundary tag |
| ext_flush | input | 1 | External flush request |
| snoop_req | input | 1 | Inquire/snoop request |
| irq_in | input | NUM_IRQ | Interrupt and init inputs to sample |
| flush_req | output | 1 | Pipeline flush request during drain |
| vid_out | output | 5 | Voltage-ID code |
| ratio_out | output | 3 | Core-to-bus clock ratio to the PLL |
| clk_gate_en | output | 1 | Gate internal clocks |
| snoop_block | output | 1 | Snoops are not allowed |
| snoop_err | output | 1 | Snoop arrived while gated |
| flush_fwd | output | 1 | Flush passed to the core |
| resume_pulse | output | 1 | One-cycle resume strobe |
| resume_tag | output | TAG_W | Boundary tag at which to resume |
| tsc | output | TSC_W | Time-stamp counter |
| irq_smp | output | NUM_IRQ | Sampled interrupt inputs |

## Verification
The sweep covers timeouts 1 to 5 against every combination of the VID enable bit and the four ratio-control codes. Gate length tells the countdown and the prescaler apart, and the VID and ratio results tell the enable-bit decode apart from the ratio-control decode. Drains are driven with only the pipeline ready, so the bench can see that the block waits for both conditions. Further cases inject writes in the middle of a sequence, write a zero timeout, and apply reset while gated, which together show the write lock, the zero filter and the counter clear.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int VID_W   = 5;
  localparam int RATIO_W = 3;

  typedef enum logic [2:0] {
    ST_NORMAL, ST_DRAIN, ST_APPLY, ST_STOPPED, ST_RESUME
  } sg_state_t;

  typedef struct packed {
    logic [1:0]         ratio_ctl;
    logic [RATIO_W-1:0] ratio;
    logic               vid_en;
    logic [VID_W-1:0]   vid;
  } sg_cfg_t;

  localparam int CFG_W = $bits(sg_cfg_t);
endpackage

// File: rtl/sg_regs.sv
module sg_regs import sg_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int TO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output sg_cfg_t           cfg,
  output logic              start,
  output logic [TO_W-1:0]   load_val
);
  logic [TO_W-1:0] to_bits;

  assign to_bits  = wr_data[TO_W-1:0];
  assign load_val = to_bits;
  assign start    = wr_en && idle && wr_addr && (to_bits != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else if (wr_en && idle && !wr_addr) cfg <= sg_cfg_t'(wr_data[CFG_W-1:0]);
  end
endmodule

// File: rtl/sg_fsm.sv
module sg_fsm import sg_pkg::*; #(
  parameter int TO_W     = 8,
  parameter int PRESCALE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [TO_W-1:0] load_val,
  input  logic            drained,
  output sg_state_t       state
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [TO_W-1:0]  cnt;
  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_NORMAL;
      cnt   <= '0;
      pre   <= '0;
    end else begin
      case (state)
        ST_NORMAL: if (start) begin
          cnt   <= load_val;
          pre   <= '0;
          state <= ST_DRAIN;
        end
        ST_DRAIN: if (drained) state <= ST_APPLY;
        ST_APPLY: state <= ST_STOPPED;
        ST_STOPPED: begin
          if (pre == PRE_LAST) begin
            pre <= '0;
            cnt <= cnt - TO_W'(1);
            if (cnt == TO_W'(1)) state <= ST_RESUME;
          end else begin
            pre <= pre + PRE_W'(1);
          end
        end
        ST_RESUME: state <= ST_NORMAL;
        default:   state <= ST_NORMAL;
      endcase
    end
  end
endmodule

// File: rtl/sg_apply.sv
module sg_apply import sg_pkg::*; #(
  parameter logic [VID_W-1:0]   RESET_VID   = 5'h10,
  parameter logic [RATIO_W-1:0] RESET_RATIO = 3'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               apply,
  input  sg_cfg_t            cfg,
  output logic [VID_W-1:0]   vid_out,
  output logic [RATIO_W-1:0] ratio_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vid_out   <= RESET_VID;
      ratio_out <= RESET_RATIO;
    end else if (apply) begin
      if (cfg.vid_en)       vid_out   <= cfg.vid;
      if (cfg.ratio_ctl[1]) ratio_out <= cfg.ratio;
    end
  end
endmodule

// File: rtl/stopgrant_ctrl.sv
module stopgrant_ctrl import sg_pkg::*; #(
  parameter int DATA_W   = 16,
  parameter int TO_W     = 8,
  parameter int PRESCALE = 4,
  parameter int TAG_W    = 8,
  parameter int TSC_W    = 16,
  parameter int NUM_IRQ  = 5,
  parameter logic [VID_W-1:0]   RESET_VID   = 5'h10,
  parameter logic [RATIO_W-1:0] RESET_RATIO = 3'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               pipe_empty,
  input  logic               bus_idle,
  input  logic [TAG_W-1:0]   bound_tag,
  input  logic               ext_flush,
  input  logic               snoop_req,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               flush_req,
  output logic [VID_W-1:0]   vid_out,
  output logic [RATIO_W-1:0] ratio_out,
  output logic               clk_gate_en,
  output logic               snoop_block,
  output logic               snoop_err,
  output logic               flush_fwd,
  output logic               resume_pulse,
  output logic [TAG_W-1:0]   resume_tag,
  output logic [TSC_W-1:0]   tsc,
  output logic [NUM_IRQ-1:0] irq_smp
);
  sg_state_t       state;
  sg_cfg_t         cfg;
  logic            start, drained, stopped;
  logic [TO_W-1:0] load_val;

  assign drained = pipe_empty && bus_idle;
  assign stopped = (state == ST_STOPPED);

  sg_regs #(.DATA_W(DATA_W), .TO_W(TO_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .idle(state == ST_NORMAL),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg), .start(start), .load_val(load_val)
  );

  sg_fsm #(.TO_W(TO_W), .PRESCALE(PRESCALE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .load_val(load_val),
    .drained(drained), .state(state)
  );

  sg_apply #(.RESET_VID(RESET_VID), .RESET_RATIO(RESET_RATIO)) u_apply (
    .clk(clk), .rst_n(rst_n), .apply(state == ST_APPLY), .cfg(cfg),
    .vid_out(vid_out), .ratio_out(ratio_out)
  );

  assign flush_req    = (state == ST_DRAIN);
  assign clk_gate_en  = stopped;
  assign snoop_block  = stopped;
  assign resume_pulse = (state == ST_RESUME);
  assign flush_fwd    = ext_flush && !stopped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsc        <= '0;
      irq_smp    <= '0;
      snoop_err  <= 1'b0;
      resume_tag <= '0;
    end else begin
      tsc       <= tsc + TSC_W'(1);
      irq_smp   <= irq_in;
      snoop_err <= snoop_req && stopped;
      if (state == ST_DRAIN && drained) resume_tag <= bound_tag;
    end
  end
endmodule

// File: rtl/sg_chk.sv
module sg_chk #(
  parameter int VW = 5,
  parameter int RW = 3,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush_req,
  input logic          pipe_empty,
  input logic          bus_idle,
  input logic [VW-1:0] vid_out,
  input logic [RW-1:0] ratio_out,
  input logic          clk_gate_en,
  input logic          snoop_req,
  input logic          snoop_block,
  input logic          snoop_err,
  input logic          flush_fwd,
  input logic          resume_pulse,
  input logic [TW-1:0] tsc
);
  logic past_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  // R3
  drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && $past(flush_req) && !flush_req |-> $past(pipe_empty && bus_idle));

  // R3
  no_flush_when_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !clk_gate_en);

  // R8
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && clk_gate_en && $past(clk_gate_en) |-> $stable(vid_out) && $stable(ratio_out));

  // R7
  resume_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  // R7
  resume_follows_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && $fell(clk_gate_en) |-> resume_pulse);

  // R9
  flush_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate_en |-> !flush_fwd);

  // R10
  snoop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid && snoop_err |-> $past(snoop_req && snoop_block));

  // R11
  tsc_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_valid |-> tsc == $past(tsc) + TW'(1));
endmodule

bind stopgrant_ctrl sg_chk #(.VW(sg_pkg::VID_W), .RW(sg_pkg::RATIO_W), .TW(TSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .pipe_empty(pipe_empty),
  .bus_idle(bus_idle), .vid_out(vid_out), .ratio_out(ratio_out),
  .clk_gate_en(clk_gate_en), .snoop_req(snoop_req), .snoop_block(snoop_block),
  .snoop_err(snoop_err), .flush_fwd(flush_fwd), .resume_pulse(resume_pulse),
  .tsc(tsc)
);

// File: tb/stopgrant_ctrl_test.sv
module stopgrant_ctrl_test;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        pipe_empty = 1'b0, bus_idle = 1'b0;
  logic [7:0]  bound_tag = '0;
  logic        ext_flush = 1'b0, snoop_req = 1'b0;
  logic [4:0]  irq_in = '0;
  logic        flush_req, clk_gate_en, snoop_block, snoop_err, flush_fwd, resume_pulse;
  logic [4:0]  vid_out, irq_smp;
  logic [2:0]  ratio_out;
  logic [7:0]  resume_tag;
  logic [15:0] tsc;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [4:0] exp_vid = 5'h10;
  logic [2:0] exp_ratio = 3'd2;

  always #4 clk = ~clk;

  stopgrant_ctrl #(.PRESCALE(P)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pipe_empty(pipe_empty), .bus_idle(bus_idle), .bound_tag(bound_tag),
    .ext_flush(ext_flush), .snoop_req(snoop_req), .irq_in(irq_in),
    .flush_req(flush_req), .vid_out(vid_out), .ratio_out(ratio_out),
    .clk_gate_en(clk_gate_en), .snoop_block(snoop_block), .snoop_err(snoop_err),
    .flush_fwd(flush_fwd), .resume_pulse(resume_pulse), .resume_tag(resume_tag),
    .tsc(tsc), .irq_smp(irq_smp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_seq(input int t, input logic [10:0] cfgv, input int dly, input bit inject, input logic [7:0] tagv);
    int n;
    logic [15:0] prev_tsc;
    pipe_empty = 0; bus_idle = 0; bound_tag = tagv;
    wr_en = 1; wr_addr = 0; wr_data = {5'd0, cfgv};
    @(negedge clk);
    wr_addr = 1; wr_data = 16'(t);
    @(negedge clk);
    wr_en = 0;
    chk(flush_req == 1'b1, "R2 start", flush_req, 1);
    if (inject) begin
      wr_en = 1; wr_addr = 1; wr_data = 16'd200;
      @(negedge clk);
      wr_addr = 0; wr_data = {5'd0, ~cfgv};
      @(negedge clk);
      wr_en = 0;
    end
    for (int i = 0; i < dly; i++) begin
      pipe_empty = (i % 2 == 0); bus_idle = 0;
      @(negedge clk);
      chk(flush_req == 1'b1, "R3 waiting", flush_req, 1);
    end
    pipe_empty = 1; bus_idle = 1;
    @(negedge clk);
    chk(!flush_req && !clk_gate_en, "R3 apply cycle", {flush_req, clk_gate_en}, 0);
    bound_tag = ~tagv; pipe_empty = 0; bus_idle = 0;
    @(negedge clk);
    if (cfgv[5]) exp_vid = cfgv[4:0];
    if (cfgv[10]) exp_ratio = cfgv[8:6];
    chk(vid_out == exp_vid, "R4 vid", vid_out, exp_vid);
    chk(ratio_out == exp_ratio, "R5 ratio", ratio_out, exp_ratio);
    n = 0; prev_tsc = tsc; ext_flush = 1;
    while (clk_gate_en && n < 5000) begin
      n++;
      chk(vid_out == exp_vid && ratio_out == exp_ratio && !flush_req, "R8 hold", vid_out, exp_vid);
      chk(!flush_fwd, "R9 flush blocked", flush_fwd, 0);
      chk(snoop_block, "R10 block", snoop_block, 1);
      if (n > 1) chk(tsc == prev_tsc + 16'd1, "R11 tsc", tsc, prev_tsc + 16'd1);
      prev_tsc = tsc;
      if (n == 1) begin snoop_req = 1; irq_in = 5'h0A ^ 5'(t); end
      if (n == 2) begin
        chk(snoop_err, "R10 snoop err", snoop_err, 1);
        chk(irq_smp == (5'h0A ^ 5'(t)), "R11 irq", irq_smp, 5'h0A ^ 5'(t));
        snoop_req = 0;
      end
      if (n == 3) chk(!snoop_err, "R10 snoop err clear", snoop_err, 0);
      @(negedge clk);
    end
    chk(n == t * P, "R6 gate length", n, t * P);
    chk(resume_pulse, "R7 resume", resume_pulse, 1);
    chk(resume_tag == tagv, "R7 tag", resume_tag, tagv);
    chk(flush_fwd, "R9 flush passes", flush_fwd, 1);
    ext_flush = 0;
    @(negedge clk);
    chk(!resume_pulse && !clk_gate_en, "R7 single", resume_pulse, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(!flush_req && !clk_gate_en && !snoop_block && !snoop_err && !resume_pulse, "R1 ctrl", 0, 0);
    chk(vid_out == 5'h10 && ratio_out == 3'd2, "R1 vid/ratio", {vid_out, ratio_out}, {5'h10, 3'd2});
    chk(tsc == 0, "R1 tsc", tsc, 0);
    rst_n = 1;
    @(negedge clk);
    // R2: zero timeout starts nothing
    wr_en = 1; wr_addr = 1; wr_data = 16'h0000;
    @(negedge clk);
    wr_en = 0;
    chk(!flush_req, "R2 zero", flush_req, 0);
    repeat (3) @(negedge clk);
    chk(!flush_req && !clk_gate_en, "R2 zero idle", clk_gate_en, 0);
    ext_flush = 1; #1;
    chk(flush_fwd, "R9 idle forward", flush_fwd, 1);
    ext_flush = 0;
    snoop_req = 1; @(negedge clk);
    chk(!snoop_err, "R10 no err idle", snoop_err, 0);
    snoop_req = 0;
    // sweep R4/R5/R6
    for (int t = 1; t <= 5; t++)
      for (int ve = 0; ve < 2; ve++)
        for (int rc = 0; rc < 4; rc++)
          run_seq(t, {2'(rc), 3'(rc + t), 1'(ve), 5'(t * 3 + rc)}, (t + rc) % 4, 1'b0, 8'(t * 16 + rc));
    // R13: writes during a sequence ignored
    run_seq(2, {2'b10, 3'd5, 1'b1, 5'h07}, 1, 1'b1, 8'h5A);
    // R12: reset while gated
    pipe_empty = 0; bus_idle = 0;
    wr_en = 1; wr_addr = 1; wr_data = 16'd50;
    @(negedge clk);
    wr_en = 0; pipe_empty = 1; bus_idle = 1;
    repeat (6) @(negedge clk);
    chk(clk_gate_en, "R12 gated before reset", clk_gate_en, 1);
    rst_n = 0; #1;
    chk(!clk_gate_en && !flush_req, "R12 async exit", clk_gate_en, 0);
    exp_vid = 5'h10; exp_ratio = 3'd2;
    chk(vid_out == exp_vid && ratio_out == exp_ratio, "R12 outputs reset", vid_out, exp_vid);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    run_seq(1, {2'b01, 3'd6, 1'b0, 5'h1F}, 0, 1'b0, 8'hC3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule